// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is one channel of a general-purpose timer. It measures the time between successive valid edges on an external input pin. Time is counted in count-clock ticks, which arrive as a one-cycle enable from a shared prescaler. Software starts the channel with a start pulse. On the first tick after the start, the counter clears and begins counting. Each later valid edge on the input copies the running count into a capture register, raises a one-cycle interrupt pulse and restarts the count from zero. Software therefore reads one pulse interval per interrupt.

The input pin is asynchronous. It passes through a tick-clocked synchronizer and, when enabled, a majority-free agreement filter. The filter rejects levels that do not persist for a number of consecutive samples. An edge-select input chooses which transitions count. A flag marks the first capture after a start, because that interval began at the start trigger and not at an edge. A second flag reports that the counter wrapped during the interval just captured. An optional interrupt on the start trigger lets software learn exactly when counting began.

Top module: `pulse_interval_timer`

## Requirements
- R1: After reset, running, count, capture, irq, cap_first and cap_ovf are all 0. A start_req pulse sets running on the next clock, and count keeps its previous value until the first count tick after that start_req.
- R2: The first count tick after a start (the start trigger) loads count with 0. Every later count tick without a valid edge adds 1 to count.
- R3: When start_irq_en is 1, the start trigger produces a one-cycle irq pulse in the clock after the trigger tick. When start_irq_en is 0, the trigger gives no irq.
- R4: On a count tick that sees a valid edge, capture takes the count value from before that tick and count becomes 0. irq pulses for one cycle in the next clock. Two valid edges N ticks apart therefore capture N-1.
- R5: cap_first is 1 after the first capture following a start and 0 after every later capture. It changes only on a capture.
- R6: edge_sel encodes the valid edge: 2'b00 rising, 2'b01 falling, 2'b10 or 2'b11 both. Transitions of the other polarity neither capture nor restart the count.
- R7: With filt_en at 0 and a count tick on every clock, a pin change applied before clock edge k is captured at edge k+2, so irq is seen in the 3rd clock cycle after the change.
- R8: With filt_en at 1, detection takes 2 more ticks, so irq is seen in the 5th cycle. A pin level held for fewer than 2 consecutive tick samples produces no capture.
- R9: count wraps from 0xFFFF to 0 without stopping. cap_ovf is set by a capture whose interval contained a wrap and is cleared by a capture whose interval did not.
- R10: A stop_req pulse clears running. While the channel is stopped, count and capture hold and irq stays 0. stop_req wins over a start_req in the same cycle.
- R11: In a clock where tick_en is 0, count, capture and the input sampling stages do not change and no irq is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-clock enable, one cycle per count tick |
| start_req | input | 1 | One-cycle start command |
| stop_req | input | 1 | One-cycle stop command |
| edge_sel | input | 2 | Valid edge: 00 rising, 01 falling, 1x both |
| filt_en | input | 1 | Enable the input agreement filter |
| start_irq_en | input | 1 | Raise irq on the start trigger |
| pin_in | input | 1 | Asynchronous measured input |
| running | output | 1 | Channel enabled status |
| count | output | CNT_W | Running interval counter |
| capture | output | CNT_W | Last captured interval |
| irq | output | 1 | One-cycle interrupt pulse |
| cap_first | output | 1 | Last capture is the first after start |
| cap_ovf | output | 1 | Last captured interval contained a wrap |

## Verification
The assertions assume start_req and stop_req are single-cycle pulses. They also assume that edge_sel, filt_en and start_irq_en change only while the channel is stopped, so that the meaning of an edge stays fixed during one measurement. The stimulus changes these settings only between stop and start. It drives pin_in and tick_en with random patterns that hold each pin level for a random number of clocks, including single-cycle glitches, so that both the filter's rejection and its acceptance are exercised.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_ANY  = 2'b10,
      EDGE_ANY2 = 2'b11
   } edge_sel_e;

   function automatic logic edge_ok(input logic [1:0] sel,
                                    input logic rise,
                                    input logic fall);
      case (sel)
         EDGE_RISE: edge_ok = rise;
         EDGE_FALL: edge_ok = fall;
         default:   edge_ok = rise | fall;
      endcase
   endfunction

endpackage

// File: rtl/pit_input_cond.sv
module pit_input_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DEPTH  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic filt_en,
   input  logic pin_in,
   output logic rise_evt,
   output logic fall_evt
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;
   logic                   lvl_q;
   logic                   lvl_next;
   logic                   filt_lvl;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pit_input_cond: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else if (tick_en) begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      end
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   if (FILT_DEPTH > 0) begin : g_filter
      logic [FILT_DEPTH-1:0] hist_q;
      logic                  agree;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hist_q <= '0;
         end else if (tick_en) begin
            if (FILT_DEPTH == 1) begin
               hist_q <= sync_out;
            end else begin
               hist_q <= {hist_q[FILT_DEPTH-2:0], sync_out};
            end
         end
      end

      assign agree    = (&hist_q) | ~(|hist_q);
      assign filt_lvl = agree ? hist_q[0] : lvl_q;
   end else begin : g_no_filter
      assign filt_lvl = sync_out;
   end

   assign lvl_next = filt_en ? filt_lvl : sync_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
      end else if (tick_en) begin
         lvl_q <= lvl_next;
      end
   end

   assign rise_evt = tick_en &  lvl_next & ~lvl_q;
   assign fall_evt = tick_en & ~lvl_next &  lvl_q;

endmodule

// File: rtl/pit_counter.sv
module pit_counter
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             start_irq_en,
   input  logic             hit,
   output logic             running,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] capture,
   output logic             irq,
   output logic             cap_first,
   output logic             cap_ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic run_q;
   logic pend_q;
   logic first_arm_q;
   logic wrap_q;
   logic active_tick;

   assign active_tick = run_q & tick_en & ~start_req & ~stop_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         pend_q      <= 1'b0;
         first_arm_q <= 1'b0;
         wrap_q      <= 1'b0;
         count       <= '0;
         capture     <= '0;
         irq         <= 1'b0;
         cap_first   <= 1'b0;
         cap_ovf     <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (stop_req) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
         end else if (start_req) begin
            run_q  <= 1'b1;
            pend_q <= 1'b1;
         end else if (active_tick) begin
            if (pend_q) begin
               pend_q      <= 1'b0;
               count       <= '0;
               first_arm_q <= 1'b1;
               wrap_q      <= 1'b0;
               irq         <= start_irq_en;
            end else if (hit) begin
               capture     <= count;
               count       <= '0;
               irq         <= 1'b1;
               cap_first   <= first_arm_q;
               first_arm_q <= 1'b0;
               cap_ovf     <= wrap_q;
               wrap_q      <= 1'b0;
            end else begin
               count <= count + 1'b1;
               if (count == CNT_MAX) begin
                  wrap_q <= 1'b1;
               end
            end
         end
      end
   end

   assign running = run_q;

endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer
   import pit_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DEPTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic [1:0]       edge_sel,
   input  logic             filt_en,
   input  logic             start_irq_en,
   input  logic             pin_in,
   output logic             running,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] capture,
   output logic             irq,
   output logic             cap_first,
   output logic             cap_ovf
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("pulse_interval_timer: CNT_W must lie in 2..32");
   end
   if (FILT_DEPTH < 0 || FILT_DEPTH > 8) begin : g_bad_filt
      $error("pulse_interval_timer: FILT_DEPTH must lie in 0..8");
   end

   logic rise_evt;
   logic fall_evt;
   logic hit;

   pit_input_cond #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_DEPTH  (FILT_DEPTH)
   ) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .filt_en  (filt_en),
      .pin_in   (pin_in),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   assign hit = edge_ok(edge_sel, rise_evt, fall_evt);

   pit_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en      (tick_en),
      .start_req    (start_req),
      .stop_req     (stop_req),
      .start_irq_en (start_irq_en),
      .hit          (hit),
      .running      (running),
      .count        (count),
      .capture      (capture),
      .irq          (irq),
      .cap_first    (cap_first),
      .cap_ovf      (cap_ovf)
   );

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             running,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] capture,
   input logic             irq,
   input logic             cap_first
);

   AST_IRQ_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(running)); // R10
   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(running) |-> $stable(count)); // R10
   AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(running) |-> $stable(capture)); // R10
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick_en) |-> ($stable(count) && $stable(capture))); // R11
   AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tick_en)); // R11
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(capture) |-> (count == '0 && irq)); // R4
   AST_FIRST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_first) |-> irq); // R5

endmodule

bind pulse_interval_timer pit_checker #(.CNT_W(CNT_W)) u_pit_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .running   (running),
   .count     (count),
   .capture   (capture),
   .irq       (irq),
   .cap_first (cap_first)
);

// File: tb/tb_pulse_interval_timer.sv
module tb_pulse_interval_timer;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b0;
   logic         start_req = 1'b0;
   logic         stop_req = 1'b0;
   logic [1:0]   edge_sel = 2'b00;
   logic         filt_en = 1'b0;
   logic         start_irq_en = 1'b0;
   logic         pin_in = 1'b0;
   logic         running;
   logic [W-1:0] count;
   logic [W-1:0] capture;
   logic         irq;
   logic         cap_first;
   logic         cap_ovf;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit cmp_en = 1'b0;

   always #10 clk = ~clk;

   pulse_interval_timer #(.CNT_W(W), .SYNC_STAGES(2), .FILT_DEPTH(2)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start_req(start_req),
      .stop_req(stop_req), .edge_sel(edge_sel), .filt_en(filt_en),
      .start_irq_en(start_irq_en), .pin_in(pin_in), .running(running),
      .count(count), .capture(capture), .irq(irq), .cap_first(cap_first),
      .cap_ovf(cap_ovf));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model built from the requirements, advanced at each rising edge
   logic [1:0]   m_s, m_f;
   logic         m_lvl, m_run, m_pend, m_irq, m_first, m_farm, m_wrap, m_ovf;
   logic [W-1:0] m_cnt, m_cap;
   logic         m_raw, m_rise, m_fall, m_hit;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s = 0; m_f = 0; m_lvl = 0; m_run = 0; m_pend = 0; m_irq = 0;
         m_first = 0; m_farm = 0; m_wrap = 0; m_ovf = 0; m_cnt = 0; m_cap = 0;
      end else begin
         m_irq  = 0;
         m_raw  = filt_en ? ((m_f[0] == m_f[1]) ? m_f[0] : m_lvl) : m_s[1];
         m_rise = tick_en && m_raw && !m_lvl;
         m_fall = tick_en && !m_raw && m_lvl;
         m_hit  = (edge_sel == 2'b00) ? m_rise :
                  (edge_sel == 2'b01) ? m_fall : (m_rise | m_fall);
         if (stop_req) begin
            m_run = 0; m_pend = 0;
         end else if (start_req) begin
            m_run = 1; m_pend = 1;
         end else if (m_run && tick_en) begin
            if (m_pend) begin
               m_pend = 0; m_cnt = 0; m_farm = 1; m_wrap = 0; m_irq = start_irq_en;
            end else if (m_hit) begin
               m_cap = m_cnt; m_cnt = 0; m_irq = 1; m_first = m_farm;
               m_farm = 0; m_ovf = m_wrap; m_wrap = 0;
            end else begin
               if (m_cnt == '1) m_wrap = 1;
               m_cnt = m_cnt + 1'b1;
            end
         end
         if (tick_en) begin
            m_lvl = m_raw;
            m_f   = {m_f[0], m_s[1]};
            m_s   = {m_s[0], pin_in};
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_en && rst_n) begin
         chk(running == m_run,     "R1 running",   running,   m_run);
         chk(count == m_cnt,       "R2 count",     count,     m_cnt);
         chk(capture == m_cap,     "R4 capture",   capture,   m_cap);
         chk(irq == m_irq,         "R4 irq",       irq,       m_irq);
         chk(cap_first == m_first, "R5 cap_first", cap_first, m_first);
         chk(cap_ovf == m_ovf,     "R9 cap_ovf",   cap_ovf,   m_ovf);
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start();
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
   endtask

   task automatic latency(output int n);
      n = 0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (irq && n == 0) n = i;
      end
   endtask

   task automatic count_irqs(input int n, output int k);
      k = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (irq) k++;
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int lat, k;
      logic [W-1:0] held_cnt, held_cap;
      void'($urandom(32'd20240611));
      cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!running && count == 0 && capture == 0 && !irq && !cap_first && !cap_ovf,
          "R1 reset state", {running, irq, cap_first, cap_ovf}, 0);
      cmp_en = 1'b1;

      // R3 start trigger with interrupt, R2 load of zero
      edge_sel = 2'b00; filt_en = 1'b0; start_irq_en = 1'b1;
      pulse_start();
      chk(running == 1'b1, "R1 running after start", running, 1);
      tick_en = 1'b1;
      @(negedge clk);
      chk(irq == 1'b1, "R3 start irq", irq, 1);
      chk(count == 0, "R2 count at trigger", count, 0);
      cyc(6);
      chk(count == 6, "R2 count increments", count, 6);

      // R7 unfiltered latency, first capture flagged (R5)
      pin_in = 1'b1;
      latency(lat);
      chk(lat == 3, "R7 latency unfiltered", lat, 3);
      chk(cap_first == 1'b1, "R5 first capture flagged", cap_first, 1);

      // R4 periodic input: rising edges 20 ticks apart capture 19
      for (int p = 0; p < 4; p++) begin
         cyc(10); pin_in = 1'b0; cyc(10); pin_in = 1'b1;
      end
      cyc(4);
      chk(capture == 19, "R4 period 20 captures 19", capture, 19);
      chk(cap_first == 1'b0, "R5 later capture not first", cap_first, 0);

      // R6 both edges, 10 ticks apart capture 9
      pulse_stop(); edge_sel = 2'b10; pulse_start();
      for (int p = 0; p < 3; p++) begin
         cyc(10); pin_in = ~pin_in;
      end
      cyc(4);
      chk(capture == 9, "R6 both edges half period", capture, 9);

      // R10 stop freezes count and capture, no irq
      cyc(3);
      pulse_stop();
      held_cnt = count; held_cap = capture;
      for (int p = 0; p < 4; p++) begin
         cyc(5); pin_in = ~pin_in;
      end
      count_irqs(10, k);
      chk(k == 0, "R10 no irq while stopped", k, 0);
      chk(count == held_cnt, "R10 count frozen", count, held_cnt);
      chk(capture == held_cap, "R10 capture frozen", capture, held_cap);

      // R1 count holds until first tick, R3 no start irq when disabled
      start_irq_en = 1'b0; edge_sel = 2'b00; pin_in = 1'b0;
      tick_en = 1'b0;
      pulse_start();
      cyc(4);
      chk(count == held_cnt, "R1 count held before trigger", count, held_cnt);
      tick_en = 1'b1;
      @(negedge clk);
      chk(count == 0 && irq == 0, "R3 no irq at start when disabled", {count, irq}, 0);

      // R11 no ticks: nothing moves
      cyc(10);
      tick_en = 1'b0; held_cnt = count;
      pin_in = 1'b1;
      count_irqs(12, k);
      chk(k == 0 && count == held_cnt, "R11 frozen without tick", count, held_cnt);
      tick_en = 1'b1;
      cyc(8);

      // R8 filtered latency and glitch rejection
      pulse_stop(); filt_en = 1'b1; pin_in = 1'b0; edge_sel = 2'b10;
      cyc(10);
      pulse_start();
      cyc(5);
      pin_in = 1'b1;
      latency(lat);
      chk(lat == 5, "R8 latency filtered", lat, 5);
      cyc(6);
      pin_in = 1'b0; @(negedge clk); pin_in = 1'b1;
      count_irqs(10, k);
      chk(k == 0, "R8 one-sample glitch rejected", k, 0);

      // R6 falling only: rising transitions ignored
      pulse_stop(); filt_en = 1'b0; edge_sel = 2'b01; pin_in = 1'b1;
      cyc(5); pulse_start(); cyc(3);
      pin_in = 1'b0; cyc(12); pin_in = 1'b1; cyc(7);
      held_cap = capture;
      chk(count >= 7, "R6 rising edge did not restart", count, 7);
      pin_in = 1'b0; cyc(4);
      chk(capture == held_cap + 0 || capture != 0, "R6 falling edge captured", capture, 1);

      // R9 counter wrap and overflow flag
      pulse_stop(); edge_sel = 2'b00; pin_in = 1'b0;
      cyc(5); pulse_start();
      cyc(65540);
      chk(count == 3, "R9 count wrapped", count, 3);
      pin_in = 1'b1; cyc(4);
      chk(cap_ovf == 1'b1, "R9 ovf after wrap", cap_ovf, 1);
      pin_in = 1'b0; cyc(6); pin_in = 1'b1; cyc(4);
      chk(cap_ovf == 1'b0, "R9 ovf cleared", cap_ovf, 0);

      // Random phases
      for (int seg = 0; seg < 40; seg++) begin
         pulse_stop();
         edge_sel = 2'($urandom_range(0, 3));
         filt_en = 1'($urandom_range(0, 1));
         start_irq_en = 1'($urandom_range(0, 1));
         cyc($urandom_range(1, 8));
         pulse_start();
         for (int n = 0; n < 60; n++) begin
            int hold;
            hold = $urandom_range(1, 12);
            for (int h = 0; h < hold; h++) begin
               tick_en = ($urandom_range(0, 9) < 7);
               @(negedge clk);
            end
            pin_in = ~pin_in;
         end
         tick_en = 1'b1;
      end

      cyc(10);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule